// File: doc/BRIEF.md
# SD Command Issue and Response Status Unit

This unit sits between a host controller's register file and its card bus engine. When software writes a 16-bit command word, the unit decodes it. It then sends a command strobe, with the index and the 32-bit argument, to the card side. After that it waits for the response. The card side returns the response one byte at a time, and closes it with a done strobe that carries the number of bytes received.

The unit checks the byte count against the response type that the command word asked for. It applies the error mask that belongs to that type and files the bytes into eight 16-bit response registers. It also produces one-cycle status-set and status-clear pulses for the status register kept elsewhere. When both pulses carry the same bit, the set wins.

A command word marked as an addressed data transfer also sends a start pulse to the data FIFO, together with the decoded direction. An initialisation-only command with index 0 does not reach the card at all and simply reports end of command.

Top module: `sd_cmdrsp_unit`

## Requirements
- R1: A command write accepted while idle produces, one clock later, a single-cycle `card_cmd_vld` with `card_cmd_idx` = word[5:0] and `card_cmd_arg` = the written argument. `busy` then stays high until the done strobe.
- R2: If word[7] (init flag) is 1 and word[5:0] is 0, the only effect one clock later is `stat_set` = 0x0001 and `stat_clr` = 0. There is no card command and `busy` stays low.
- R3: A command write while `busy` is high has no effect: no card command is issued and the pending response is still evaluated under the first command.
- R4: word[10:8] selects the response type. Types 1, 3 and 6 need `rsp_len` >= 4 and type 2 needs `rsp_len` >= 16. A shorter response gives `stat_set` = 0x0080 (bit 7, timeout) and `stat_clr` = 0x4FFF, and the response registers stay zero.
- R5: For type 1, with or without the busy flag word[11], the status word is {byte0,byte1,byte2,byte3}. Any bit set under mask 0xFDF90000 gives `stat_set` bit 14 and leaves `stat_clr` at 0. With no error, `stat_clr` = 0x4FFF.
- R6: Bit 3 of the type-1 status word, the authentication-sequence error, counts as an error only while `ake_chk_en` is 1.
- R7: For type 6, the status word is {byte2,byte3} and the error mask is 0xE008. It gives bit 14 and the clear pattern in the same way as R5.
- R8: For type 3, if bit 31 of {byte0..byte3} is 0, `stat_set` bit 12 (card busy) is set and `stat_clr` = 0x4FFF. If bit 31 is 1, `stat_clr` = 0x5FFF and bit 12 is not set.
- R9: On a successful typed response, the register for word j (at `rsp_words[16*j +: 16]`) becomes {byte[14-2j], byte[15-2j]}. Byte pair 0/1 therefore lands in word 7. Bytes that were never received read as zero.
- R10: All eight response registers read zero in the cycle `card_cmd_vld` is high.
- R11: A successful response sets `stat_set` bit 0. When the index is 12, bits 0 and 2 are both set (0x0005 with no other bits).
- R12: When word[13:12] = 1, `xfer_start` pulses together with `card_cmd_vld`, and `xfer_dir` = word[15]. For any other command type, `xfer_start` stays low.
- R13: Types 0, 4, 5 and 7 expect no response. There is no length check, the registers stay zero, `stat_set` = 0x0001 and `stat_clr` = 0x4FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ake_chk_en | input | 1 | Include the authentication-sequence flag in the type-1 error mask |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Command word |
| cmd_arg | input | 32 | Command argument |
| rsp_byte_vld | input | 1 | Response byte valid |
| rsp_byte | input | 8 | Response byte, first received first |
| rsp_done | input | 1 | End of response |
| rsp_len | input | 5 | Number of response bytes, valid with rsp_done |
| busy | output | 1 | Waiting for a response |
| card_cmd_vld | output | 1 | Command strobe to the card side |
| card_cmd_idx | output | 6 | Command index |
| card_cmd_arg | output | 32 | Command argument |
| xfer_start | output | 1 | Data FIFO start pulse |
| xfer_dir | output | 1 | Data direction for the FIFO (1 = from card) |
| stat_set | output | 16 | One-cycle status bits to set |
| stat_clr | output | 16 | One-cycle status bits to clear |
| rsp_words | output | 128 | Eight response registers, word j at [16*j +: 16] |

## Verification
The bench sends a type-2 response that is too short, and a full one. A design that judged length by the wrong type, or stored bytes on a timeout, would show non-zero registers or miss bit 7. It drives the authentication flag with the enable off and on, and a type-3 word with bit 31 both low and high. These expose a mask that is fixed or a clear pattern that is too narrow. It also checks the reversed word order, the index-12 extra bit, the clearing of old response data on the next command, and a command written while busy. A unit that accepted that write would issue a second strobe.

// File: rtl/sdcr_pkg.sv
package sdcr_pkg;
  localparam int RSP_WORDS = 8;
  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int RSP_BYTES = RSP_WORDS * WORD_W / BYTE_W;
  localparam int STAT_W    = 16;
  localparam int IDX_W     = 6;
  localparam int ARG_W     = 32;

  localparam logic [31:0] R1_ERR_MASK = 32'hFDF9_0000;
  localparam logic [31:0] AKE_BIT     = 32'h0000_0008;
  localparam logic [15:0] R6_ERR_MASK = 16'hE008;
  localparam logic [15:0] CLR_OK      = 16'h4FFF;
  localparam logic [15:0] CLR_R3_RDY  = 16'h1FFF;
  localparam int ST_EOC  = 0;
  localparam int ST_STOP = 2;
  localparam int ST_TO   = 7;
  localparam int ST_CBSY = 12;
  localparam int ST_CERR = 14;
  localparam logic [5:0] STOP_IDX = 6'd12;

  typedef enum logic [2:0] {
    RK_NONE, RK_SHORT, RK_SHORT_BSY, RK_LONG, RK_COND, RK_ADDR
  } rsp_kind_e;

  typedef struct packed {
    logic       dir;
    logic [1:0] ctype;
    logic       bsy;
    logic [2:0] rtype;
    logic       init;
    logic [5:0] idx;
  } cmd_fields_t;

  typedef enum logic [0:0] { S_IDLE, S_WAIT } cr_state_e;
endpackage

// File: rtl/sdcr_rst_sync.sv
module sdcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sdcr_cmd_decode.sv
module sdcr_cmd_decode
  import sdcr_pkg::*;
(
  input  logic [15:0] word,
  output cmd_fields_t fields,
  output rsp_kind_e   kind,
  output logic        init_only,
  output logic        is_data
);
  always_comb begin
    fields.idx   = word[5:0];
    fields.init  = word[7];
    fields.rtype = word[10:8];
    fields.bsy   = word[11];
    fields.ctype = word[13:12];
    fields.dir   = word[15];
  end

  always_comb begin
    case (fields.rtype)
      3'd1:    kind = fields.bsy ? RK_SHORT_BSY : RK_SHORT;
      3'd2:    kind = RK_LONG;
      3'd3:    kind = RK_COND;
      3'd6:    kind = RK_ADDR;
      default: kind = RK_NONE;
    endcase
  end

  assign init_only = fields.init && (fields.idx == '0);
  assign is_data   = (fields.ctype == 2'd1);
endmodule

// File: rtl/sdcr_rsp_buffer.sv
module sdcr_rsp_buffer
  import sdcr_pkg::*;
#(
  parameter int NBYTES = RSP_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr,
  input  logic [BYTE_W-1:0]     din,
  output logic [NBYTES*BYTE_W-1:0] bytes
);
  localparam int CNT_W = $clog2(NBYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             room;

  assign room = (cnt_q < CNT_W'(NBYTES));

  always_comb begin
    cnt_n = cnt_q;
    if (clr)             cnt_n = '0;
    else if (wr && room) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] d_q, d_n;
    logic              en;
    assign en = clr || (wr && room && (cnt_q == CNT_W'(b)));
    always_comb d_n = clr ? '0 : din;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  d_q <= '0;
      else if (en) d_q <= d_n;
    end
    assign bytes[b*BYTE_W +: BYTE_W] = d_q;
  end

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NBYTES));
endmodule

// File: rtl/sdcr_rsp_eval.sv
module sdcr_rsp_eval
  import sdcr_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  rsp_kind_e                   kind,
  input  logic [IDX_W-1:0]            idx,
  input  logic [LEN_W-1:0]            len,
  input  logic                        ake_en,
  input  logic [RSP_BYTES*BYTE_W-1:0] bytes,
  output logic [STAT_W-1:0]           set_bits,
  output logic [STAT_W-1:0]           clr_bits,
  output logic                        store,
  output logic [RSP_WORDS*WORD_W-1:0] words
);
  localparam int SHORT_LEN = 4;
  localparam int LONG_LEN  = RSP_BYTES;

  logic [31:0] head32;
  logic [15:0] tail16;
  logic [31:0] r1_mask;
  logic        too_short;
  logic        err;

  assign head32  = {bytes[0 +: 8], bytes[8 +: 8], bytes[16 +: 8], bytes[24 +: 8]};
  assign tail16  = {bytes[16 +: 8], bytes[24 +: 8]};
  assign r1_mask = R1_ERR_MASK | (ake_en ? AKE_BIT : 32'h0);

  always_comb begin
    case (kind)
      RK_SHORT, RK_SHORT_BSY, RK_COND, RK_ADDR:
        too_short = (len < LEN_W'(SHORT_LEN));
      RK_LONG:
        too_short = ({1'b0, len} < (LEN_W+1)'(LONG_LEN));
      default:
        too_short = 1'b0;
    endcase
  end

  always_comb begin
    set_bits = '0;
    clr_bits = '0;
    store    = 1'b0;
    err      = 1'b0;
    if (too_short) begin
      set_bits[ST_TO] = 1'b1;
      clr_bits        = CLR_OK;
    end else begin
      store = (kind != RK_NONE);
      case (kind)
        RK_SHORT, RK_SHORT_BSY: err = |(head32 & r1_mask);
        RK_ADDR:                err = |(tail16 & R6_ERR_MASK);
        RK_COND: begin
          if (head32[31]) clr_bits = clr_bits | CLR_R3_RDY;
          else            set_bits[ST_CBSY] = 1'b1;
        end
        default: err = 1'b0;
      endcase
      if (err) set_bits[ST_CERR] = 1'b1;
      else     clr_bits = clr_bits | CLR_OK;
      set_bits[ST_EOC] = 1'b1;
      if (idx == STOP_IDX) set_bits[ST_STOP] = 1'b1;
    end
  end

  for (genvar j = 0; j < RSP_WORDS; j++) begin : g_pack
    localparam int HI = 2 * (RSP_WORDS - 1 - j);
    assign words[j*WORD_W +: WORD_W] =
      {bytes[HI*BYTE_W +: BYTE_W], bytes[(HI+1)*BYTE_W +: BYTE_W]};
  end
endmodule

// File: rtl/sd_cmdrsp_unit.sv
module sd_cmdrsp_unit
  import sdcr_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ake_chk_en,
  input  logic                        cmd_wr,
  input  logic [15:0]                 cmd_word,
  input  logic [ARG_W-1:0]            cmd_arg,
  input  logic                        rsp_byte_vld,
  input  logic [BYTE_W-1:0]           rsp_byte,
  input  logic                        rsp_done,
  input  logic [LEN_W-1:0]            rsp_len,
  output logic                        busy,
  output logic                        card_cmd_vld,
  output logic [IDX_W-1:0]            card_cmd_idx,
  output logic [ARG_W-1:0]            card_cmd_arg,
  output logic                        xfer_start,
  output logic                        xfer_dir,
  output logic [STAT_W-1:0]           stat_set,
  output logic [STAT_W-1:0]           stat_clr,
  output logic [RSP_WORDS*WORD_W-1:0] rsp_words
);
  localparam int RSP_W = RSP_WORDS * WORD_W;

  logic rst_ns;
  sdcr_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  cmd_fields_t f;
  rsp_kind_e   dec_kind;
  logic        dec_init0, dec_data;

  sdcr_cmd_decode u_dec (
    .word(cmd_word), .fields(f), .kind(dec_kind),
    .init_only(dec_init0), .is_data(dec_data)
  );

  cr_state_e        state_q, state_n;
  rsp_kind_e        kind_q, kind_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [ARG_W-1:0] arg_q, arg_n;
  logic             vld_q, vld_n;
  logic             xs_q, xs_n;
  logic             xd_q, xd_n;
  logic [STAT_W-1:0] set_q, set_n, clr_q, clr_n;
  logic [RSP_W-1:0] rsp_q, rsp_n;
  logic             accept, buf_clr, buf_wr;

  logic [RSP_BYTES*BYTE_W-1:0] buf_bytes;
  logic [STAT_W-1:0] ev_set, ev_clr;
  logic              ev_store;
  logic [RSP_W-1:0]  ev_words;

  assign accept  = cmd_wr && (state_q == S_IDLE);
  assign buf_clr = accept;
  assign buf_wr  = (state_q == S_WAIT) && rsp_byte_vld && !rsp_done;

  sdcr_rsp_buffer #(.NBYTES(RSP_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_ns), .clr(buf_clr), .wr(buf_wr),
    .din(rsp_byte), .bytes(buf_bytes)
  );

  sdcr_rsp_eval #(.LEN_W(LEN_W)) u_eval (
    .kind(kind_q), .idx(idx_q), .len(rsp_len), .ake_en(ake_chk_en),
    .bytes(buf_bytes), .set_bits(ev_set), .clr_bits(ev_clr),
    .store(ev_store), .words(ev_words)
  );

  always_comb begin
    state_n = state_q;
    kind_n  = kind_q;
    idx_n   = idx_q;
    arg_n   = arg_q;
    xd_n    = xd_q;
    rsp_n   = rsp_q;
    vld_n   = 1'b0;
    xs_n    = 1'b0;
    set_n   = '0;
    clr_n   = '0;
    if (accept) begin
      rsp_n = '0;
      if (dec_init0) begin
        set_n[ST_EOC] = 1'b1;
      end else begin
        vld_n   = 1'b1;
        idx_n   = f.idx;
        arg_n   = cmd_arg;
        kind_n  = dec_kind;
        xs_n    = dec_data;
        if (dec_data) xd_n = f.dir;
        state_n = S_WAIT;
      end
    end else if ((state_q == S_WAIT) && rsp_done) begin
      set_n   = ev_set;
      clr_n   = ev_clr;
      if (ev_store) rsp_n = ev_words;
      state_n = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= S_IDLE;
      kind_q  <= RK_NONE;
      idx_q   <= '0;
      arg_q   <= '0;
      vld_q   <= 1'b0;
      xs_q    <= 1'b0;
      xd_q    <= 1'b0;
      set_q   <= '0;
      clr_q   <= '0;
      rsp_q   <= '0;
    end else begin
      state_q <= state_n;
      kind_q  <= kind_n;
      idx_q   <= idx_n;
      arg_q   <= arg_n;
      vld_q   <= vld_n;
      xs_q    <= xs_n;
      xd_q    <= xd_n;
      set_q   <= set_n;
      clr_q   <= clr_n;
      rsp_q   <= rsp_n;
    end
  end

  assign busy         = (state_q == S_WAIT);
  assign card_cmd_vld = vld_q;
  assign card_cmd_idx = idx_q;
  assign card_cmd_arg = arg_q;
  assign xfer_start   = xs_q;
  assign xfer_dir     = xd_q;
  assign stat_set     = set_q;
  assign stat_clr     = clr_q;
  assign rsp_words    = rsp_q;

  assert_one_shot_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    card_cmd_vld |=> !card_cmd_vld);
  assert_init_only_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (cmd_wr && !busy && cmd_word[7] && cmd_word[5:0] == 6'd0)
      |=> (!card_cmd_vld && !busy && stat_set == 16'h0001));
  assert_no_reissue_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && !rsp_done) |=> !card_cmd_vld);
  assert_timeout_alone_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    stat_set[ST_TO] |-> (!stat_set[ST_EOC] && !stat_set[ST_CERR]));
  assert_cleared_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    card_cmd_vld |-> (rsp_words == '0));
  assert_stop_pair_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    stat_set[ST_STOP] |-> stat_set[ST_EOC]);
  assert_xfer_with_cmd_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    xfer_start |-> card_cmd_vld);
endmodule

// File: tb/sd_cmdrsp_unit_test.sv
module sd_cmdrsp_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ake_chk_en = 1'b0;
  logic cmd_wr = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [31:0] cmd_arg = '0;
  logic rsp_byte_vld = 1'b0;
  logic [7:0] rsp_byte = '0;
  logic rsp_done = 1'b0;
  logic [4:0] rsp_len = '0;
  logic busy, card_cmd_vld, xfer_start, xfer_dir;
  logic [5:0] card_cmd_idx;
  logic [31:0] card_cmd_arg;
  logic [15:0] stat_set, stat_clr;
  logic [127:0] rsp_words;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] bq [16];

  always #4 clk = ~clk;

  sd_cmdrsp_unit uut (
    .clk(clk), .rst_n(rst_n), .ake_chk_en(ake_chk_en), .cmd_wr(cmd_wr),
    .cmd_word(cmd_word), .cmd_arg(cmd_arg), .rsp_byte_vld(rsp_byte_vld),
    .rsp_byte(rsp_byte), .rsp_done(rsp_done), .rsp_len(rsp_len),
    .busy(busy), .card_cmd_vld(card_cmd_vld), .card_cmd_idx(card_cmd_idx),
    .card_cmd_arg(card_cmd_arg), .xfer_start(xfer_start), .xfer_dir(xfer_dir),
    .stat_set(stat_set), .stat_clr(stat_clr), .rsp_words(rsp_words)
  );

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      summary();
    end
  end

  function automatic logic [127:0] packed_exp();
    logic [127:0] r = '0;
    for (int j = 0; j < 8; j++)
      r[j*16 +: 16] = {bq[14-2*j], bq[15-2*j]};
    return r;
  endfunction

  task automatic clear_q();
    for (int i = 0; i < 16; i++) bq[i] = 8'h00;
  endtask

  task automatic issue(input logic [15:0] w, input logic [31:0] a);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = w; cmd_arg = a;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic respond(input int nbytes, input logic [4:0] len);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      rsp_byte_vld = 1'b1; rsp_byte = bq[i];
    end
    @(negedge clk);
    rsp_byte_vld = 1'b0; rsp_done = 1'b1; rsp_len = len;
    @(negedge clk);
    rsp_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset busy", {127'b0, busy}, 128'd0);
    chk("R1 reset cmd", {127'b0, card_cmd_vld}, 128'd0);
    chk("R1 reset set", {112'b0, stat_set}, 128'd0);
    chk("R10 reset regs", rsp_words, 128'd0);
  endtask

  task automatic t_init0();
    issue(16'h0080, 32'h0);
    chk("R2 no card cmd", {127'b0, card_cmd_vld}, 128'd0);
    chk("R2 set eoc", {112'b0, stat_set}, 128'h1);
    chk("R2 clr none", {112'b0, stat_clr}, 128'h0);
    chk("R2 not busy", {127'b0, busy}, 128'd0);
  endtask

  task automatic t_r1_ok();
    issue(16'h0111, 32'hCAFE_0042);
    chk("R1 strobe", {127'b0, card_cmd_vld}, 128'd1);
    chk("R1 idx", {122'b0, card_cmd_idx}, 128'd17);
    chk("R1 arg", {96'b0, card_cmd_arg}, {96'b0, 32'hCAFE_0042});
    chk("R12 no xfer", {127'b0, xfer_start}, 128'd0);
    clear_q(); bq[2] = 8'h09;
    respond(4, 5'd4);
    chk("R5 ok set", {112'b0, stat_set}, 128'h0001);
    chk("R5 ok clr", {112'b0, stat_clr}, 128'h4FFF);
    chk("R9 r1 words", rsp_words, packed_exp());
  endtask

  task automatic t_r1_err();
    issue(16'h0911, 32'h0);
    clear_q(); bq[1] = 8'h40;
    respond(4, 5'd4);
    chk("R5 err set", {112'b0, stat_set}, 128'h4001);
    chk("R5 err clr", {112'b0, stat_clr}, 128'h0);
  endtask

  task automatic t_ake();
    ake_chk_en = 1'b0;
    issue(16'h0111, 32'h0);
    clear_q(); bq[3] = 8'h08;
    respond(4, 5'd4);
    chk("R6 ake off", {112'b0, stat_set}, 128'h0001);
    ake_chk_en = 1'b1;
    issue(16'h0111, 32'h0);
    respond(4, 5'd4);
    chk("R6 ake on", {112'b0, stat_set}, 128'h4001);
    ake_chk_en = 1'b0;
  endtask

  task automatic t_r2();
    issue(16'h0202, 32'h0);
    clear_q();
    for (int i = 0; i < 4; i++) bq[i] = 8'h55;
    respond(4, 5'd4);
    chk("R4 timeout set", {112'b0, stat_set}, 128'h0080);
    chk("R4 timeout clr", {112'b0, stat_clr}, 128'h4FFF);
    chk("R4 regs zero", rsp_words, 128'd0);
    issue(16'h0202, 32'h0);
    for (int i = 0; i < 16; i++) bq[i] = 8'(8'h10 + i);
    respond(16, 5'd16);
    chk("R9 long set", {112'b0, stat_set}, 128'h0001);
    chk("R9 long order", rsp_words, packed_exp());
  endtask

  task automatic t_clear_on_cmd();
    issue(16'h0007, 32'h0);
    chk("R10 cleared", rsp_words, 128'd0);
    clear_q(); bq[0] = 8'hAA; bq[1] = 8'hBB;
    respond(2, 5'd2);
    chk("R13 none set", {112'b0, stat_set}, 128'h0001);
    chk("R13 none clr", {112'b0, stat_clr}, 128'h4FFF);
    chk("R13 regs zero", rsp_words, 128'd0);
  endtask

  task automatic t_r3();
    issue(16'h0329, 32'h0);
    clear_q(); bq[1] = 8'hFF; bq[2] = 8'h80;
    respond(4, 5'd4);
    chk("R8 busy set", {112'b0, stat_set}, 128'h1001);
    chk("R8 busy clr", {112'b0, stat_clr}, 128'h4FFF);
    issue(16'h0329, 32'h0);
    bq[0] = 8'h80;
    respond(4, 5'd4);
    chk("R8 ready set", {112'b0, stat_set}, 128'h0001);
    chk("R8 ready clr", {112'b0, stat_clr}, 128'h5FFF);
  endtask

  task automatic t_r6();
    issue(16'h0603, 32'h0);
    clear_q(); bq[0] = 8'hAA; bq[1] = 8'hBB; bq[2] = 8'h20;
    respond(4, 5'd4);
    chk("R7 err", {112'b0, stat_set}, 128'h4001);
    issue(16'h0603, 32'h0);
    bq[2] = 8'h01;
    respond(4, 5'd4);
    chk("R7 ok set", {112'b0, stat_set}, 128'h0001);
    chk("R7 ok clr", {112'b0, stat_clr}, 128'h4FFF);
  endtask

  task automatic t_stop();
    issue(16'h010C, 32'h0);
    clear_q();
    respond(4, 5'd4);
    chk("R11 stop", {112'b0, stat_set}, 128'h0005);
  endtask

  task automatic t_xfer();
    issue(16'h9111, 32'h0);
    chk("R12 start", {127'b0, xfer_start}, 128'd1);
    chk("R12 dir", {127'b0, xfer_dir}, 128'd1);
    clear_q();
    respond(4, 5'd4);
  endtask

  task automatic t_busy_ignore();
    issue(16'h0111, 32'h1);
    issue(16'h010C, 32'h2);
    chk("R3 no reissue", {127'b0, card_cmd_vld}, 128'd0);
    chk("R3 still busy", {127'b0, busy}, 128'd1);
    clear_q();
    respond(4, 5'd4);
    chk("R3 first kept", {112'b0, stat_set}, 128'h0001);
    chk("R3 idx kept", {122'b0, card_cmd_idx}, 128'd17);
  endtask

  initial begin
    clear_q();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_init0();
    t_r1_ok();
    t_r1_err();
    t_ake();
    t_r2();
    t_clear_on_cmd();
    t_r3();
    t_r6();
    t_stop();
    t_xfer();
    t_busy_ignore();
    summary();
  end
endmodule